// File: doc/BRIEF.md
# Three-Port CPU Register File

This block is the architectural register file of a 32-bit load/store processor core. It keeps 32 general-purpose registers of one 32-bit word each. Two independent read ports and one write port can all be used in the same clock cycle. Each read port decodes a 5-bit index and returns the selected word combinationally, so the decode stage of a pipeline sees operands without an extra cycle of latency. The write port commits one word on the rising clock edge while its enable is high.

Index 0 is a constant zero. It always reads as zero, and writes aimed at it are dropped without any indication. There is no internal bypass. A read that targets the register being written in the same cycle shows the old contents until the edge and the new contents after it. Any forwarding belongs to the pipeline around the block.

Reset is asynchronous and active-low. It clears every register at once, and the block releases it internally through a two-stage synchronizer.

Top module: `regfile3p`

## Requirements
- R1: While `rst_n` is low, every register reads as zero. Writes presented in the first two rising edges after `rst_n` rises are dropped, because reset is still held inside the block during that time.
- R2: With `wr_en` = 1 and `wr_addr` in 1..31, the word on `wr_data` is stored in register `wr_addr` on the rising edge. It is visible on a read port from the following cycle on.
- R3: With `wr_en` = 0, no register changes on a clock edge, whatever `wr_addr` and `wr_data` hold.
- R4: Each read port is combinational. `rd_a_data` and `rd_b_data` show the register selected by `rd_a_addr` and `rd_b_addr` in the same cycle the address is applied, with no clock edge in between.
- R5: When both read addresses are equal, both read data outputs carry the same word.
- R6: Reading index 0 on either port returns 32'h0000_0000 at all times.
- R7: A write to index 0 with `wr_en` = 1 has no effect, and index 0 keeps reading as zero.
- R8: When a read address equals the write address during a write cycle, the read port shows the old contents before the edge and the new contents after it. There is no bypass.
- R9: A write changes only the addressed register. All other registers keep their contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes commit on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rd_a_addr | input | 5 | Register index for read port A |
| rd_a_data | output | 32 | Contents of the register selected on port A |
| rd_b_addr | input | 5 | Register index for read port B |
| rd_b_data | output | 32 | Contents of the register selected on port B |
| wr_en | input | 1 | Write enable for the write port |
| wr_addr | input | 5 | Register index for the write port |
| wr_data | input | 32 | Word to be written |

## Verification
The clocked properties are disabled only while the external `rst_n` is low. They therefore assume that no write is issued in the two cycles after reset release, while the internal synchronizer still holds the registers cleared. The properties about held or landed values also assume that read addresses change only between clock edges. The bench drives every input once per cycle on the falling edge. After each release of reset it runs three idle cycles with `wr_en` low before it issues any write.

// File: rtl/rf_pkg.sv
`timescale 1ns/1ps
package rf_pkg;
  // Default geometry of the register file
  localparam int unsigned RF_DATA_W   = 32;
  localparam int unsigned RF_NUM_REGS = 32;
  // Index that is hardwired to zero
  localparam int unsigned RF_ZERO_IDX = 0;
endpackage

// File: rtl/rf_rst_sync.sv
`timescale 1ns/1ps
// Asynchronous assert, synchronous release of the active-low reset
module rf_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rf_wr_decode.sv
`timescale 1ns/1ps
// One-hot row enables for the write port; index 0 never gets one
module rf_wr_decode #(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  output logic [NUM_REGS-1:1]   row_we
);
  always_comb begin
    row_we = '0;
    for (int r = 1; r < int'(NUM_REGS); r++) begin
      if (wr_en && (int'(wr_addr) == r)) begin
        row_we[r] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rf_storage.sv
`timescale 1ns/1ps
// Register rows; row 0 is a constant, the rest are flops with enables
module rf_storage #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_REGS-1:1]  row_we,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rows [NUM_REGS]
);
  genvar gi;
  generate
    for (gi = 0; gi < int'(NUM_REGS); gi++) begin : g_row
      if (gi == int'(rf_pkg::RF_ZERO_IDX)) begin : g_const
        assign rows[gi] = '0;
      end else begin : g_flop
        logic [DATA_W-1:0] row_d;
        logic [DATA_W-1:0] row_q;

        always_comb begin
          row_d = row_q;
          if (row_we[gi]) begin
            row_d = wr_data;
          end
        end

        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            row_q <= '0;
          end else begin
            row_q <= row_d;
          end
        end

        assign rows[gi] = row_q;
      end
    end
  endgenerate
endmodule

// File: rtl/rf_read_port.sv
`timescale 1ns/1ps
// Combinational read selector; out-of-range indices read as zero
module rf_read_port #(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned ADDR_W   = 5
) (
  input  logic [DATA_W-1:0]  rows [NUM_REGS],
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data
);
  always_comb begin
    rd_data = '0;
    for (int r = 0; r < int'(NUM_REGS); r++) begin
      if (int'(rd_addr) == r) begin
        rd_data = rows[r];
      end
    end
  end
endmodule

// File: rtl/regfile3p.sv
`timescale 1ns/1ps
// Two-read, one-write register file with a hardwired zero register
module regfile3p #(
  parameter int unsigned DATA_W   = rf_pkg::RF_DATA_W,
  parameter int unsigned NUM_REGS = rf_pkg::RF_NUM_REGS,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [$clog2(NUM_REGS)-1:0]  rd_a_addr,
  output logic [DATA_W-1:0]            rd_a_data,
  input  logic [$clog2(NUM_REGS)-1:0]  rd_b_addr,
  output logic [DATA_W-1:0]            rd_b_data,
  input  logic                         wr_en,
  input  logic [$clog2(NUM_REGS)-1:0]  wr_addr,
  input  logic [DATA_W-1:0]            wr_data
);
  localparam int unsigned ADDR_W = $clog2(NUM_REGS);

  logic                 rst_core_n;
  logic [NUM_REGS-1:1]  row_we;
  logic [DATA_W-1:0]    rows [NUM_REGS];

  rf_rst_sync #(
    .STAGES (RST_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  rf_wr_decode #(
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_wr_decode (
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .row_we  (row_we)
  );

  rf_storage #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS)
  ) u_storage (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .row_we  (row_we),
    .wr_data (wr_data),
    .rows    (rows)
  );

  rf_read_port #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_rd_a (
    .rows    (rows),
    .rd_addr (rd_a_addr),
    .rd_data (rd_a_data)
  );

  rf_read_port #(
    .DATA_W   (DATA_W),
    .NUM_REGS (NUM_REGS),
    .ADDR_W   (ADDR_W)
  ) u_rd_b (
    .rows    (rows),
    .rd_addr (rd_b_addr),
    .rd_data (rd_b_data)
  );
endmodule

// File: rtl/rf_checker.sv
`timescale 1ns/1ps
module rf_checker #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] rd_a_addr,
  input logic [DATA_W-1:0] rd_a_data,
  input logic [ADDR_W-1:0] rd_b_addr,
  input logic [DATA_W-1:0] rd_b_data,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  AST_ZERO_READ_A: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == '0) |-> (rd_a_data == '0));  // R6
  AST_ZERO_READ_B: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_b_addr == '0) |-> (rd_b_data == '0));  // R6
  AST_SAME_INDEX_SAME_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_a_addr == rd_b_addr) |-> (rd_a_data == rd_b_data));  // R5
  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr != '0) && (rd_a_addr == wr_addr))
    |=> (!$stable(rd_a_addr) || (rd_a_data == $past(wr_data))));  // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en) |=> (!$stable(rd_a_addr) || $stable(rd_a_data)));  // R3
  AST_ZERO_WRITE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (wr_addr == '0)) |=> (!$stable(rd_b_addr) || $stable(rd_b_data)));  // R7
endmodule

bind regfile3p rf_checker #(
  .DATA_W (DATA_W),
  .ADDR_W (ADDR_W)
) u_rf_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .rd_a_addr (rd_a_addr),
  .rd_a_data (rd_a_data),
  .rd_b_addr (rd_b_addr),
  .rd_b_data (rd_b_data),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data)
);

// File: tb/regfile3p_test.sv
`timescale 1ns/1ps
module regfile3p_test;
  logic        clk;
  logic        rst_n;
  logic [4:0]  rd_a_addr;
  logic [31:0] rd_a_data;
  logic [4:0]  rd_b_addr;
  logic [31:0] rd_b_data;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [31:0] wr_data;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  typedef struct {
    logic [4:0]  a_addr;
    logic [4:0]  b_addr;
    logic [31:0] exp_a;
    logic [31:0] exp_b;
    string       tag;
  } item_t;

  item_t       sb_q[$];
  logic [31:0] model [32];

  regfile3p uut (
    .clk(clk), .rst_n(rst_n),
    .rd_a_addr(rd_a_addr), .rd_a_data(rd_a_data),
    .rd_b_addr(rd_b_addr), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  function automatic logic [31:0] pattern(input int idx, input logic [31:0] seed);
    return seed ^ (32'h0101_0101 * idx) ^ {idx[7:0], 24'h0};
  endfunction

  function automatic logic [31:0] expect_of(input logic [4:0] a);
    return (a == 5'd0) ? 32'h0 : model[a];
  endfunction

  // Driver: one cycle of stimulus, expected reads pushed for the monitor
  task automatic step(input logic we, input logic [4:0] wa, input logic [31:0] wd,
                      input logic [4:0] ra, input logic [4:0] rb, input string tag);
    item_t it;
    @(negedge clk);
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_a_addr = ra; rd_b_addr = rb;
    it.a_addr = ra; it.b_addr = rb;
    it.exp_a = expect_of(ra); it.exp_b = expect_of(rb);
    it.tag = tag;
    sb_q.push_back(it);
    if (we && wa != 5'd0) model[wa] = wd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 1'b0;
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: compares the design outputs against queued expectations
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rd_a_data !== it.exp_a) begin
          errors++;
          $display("FAIL %s port A addr=%0d actual=%08h expected=%08h",
                   it.tag, it.a_addr, rd_a_data, it.exp_a);
        end
        checks++;
        if (rd_b_data !== it.exp_b) begin
          errors++;
          $display("FAIL %s port B addr=%0d actual=%08h expected=%08h",
                   it.tag, it.b_addr, rd_b_data, it.exp_b);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_a_addr = '0; rd_b_addr = '0;
    for (int i = 0; i < 32; i++) model[i] = 32'h0;
    repeat (3) @(negedge clk);
    // R1: reads during reset
    step(1'b0, 5'd0, 32'h0, 5'd3, 5'd30, "R1");
    rst_n = 1'b1;
    step(1'b0, 5'd0, 32'h0, 5'd1, 5'd31, "R1");
    step(1'b0, 5'd0, 32'h0, 5'd5, 5'd17, "R1");
    step(1'b0, 5'd0, 32'h0, 5'd9, 5'd22, "R1");

    // R2 / R8: fill all registers, reading the target during the write
    for (int i = 1; i < 32; i++) begin
      step(1'b1, 5'(i), pattern(i, 32'hA5C3_0F00), 5'(i), 5'(i - 1), "R2_R8");
    end

    // R4: sweep reads in consecutive cycles, no writes
    for (int i = 0; i < 32; i++) begin
      step(1'b0, 5'(31 - i), 32'hFFFF_FFFF, 5'(i), 5'(31 - i), "R4");
    end

    // R5: both ports on the same index
    for (int i = 0; i < 32; i += 5) begin
      step(1'b0, 5'd0, 32'h0, 5'(i), 5'(i), "R5");
    end

    // R6: index 0 on both ports with busy writes elsewhere
    step(1'b1, 5'd12, 32'h1234_5678, 5'd0, 5'd0, "R6");
    step(1'b0, 5'd0, 32'h0, 5'd0, 5'd12, "R6");

    // R7: write to index 0 is dropped, neighbours untouched
    step(1'b1, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd1, "R7");
    step(1'b0, 5'd0, 32'hFFFF_FFFF, 5'd0, 5'd0, "R7");
    step(1'b0, 5'd0, 32'h0, 5'd1, 5'd31, "R7");

    // R3: enable low with live address and data
    step(1'b0, 5'd7, 32'hDEAD_BEEF, 5'd7, 5'd8, "R3");
    step(1'b0, 5'd7, 32'hDEAD_BEEF, 5'd7, 5'd8, "R3");
    step(1'b0, 5'd31, 32'h0BAD_F00D, 5'd31, 5'd7, "R3");

    // R8: read-during-write shows old, then new
    step(1'b1, 5'd9, 32'hC0FF_EE00, 5'd9, 5'd9, "R8");
    step(1'b0, 5'd0, 32'h0, 5'd9, 5'd9, "R8");

    // R9: only the addressed register changes
    step(1'b1, 5'd10, 32'h5555_AAAA, 5'd9, 5'd11, "R9");
    step(1'b0, 5'd0, 32'h0, 5'd9, 5'd11, "R9");
    step(1'b0, 5'd0, 32'h0, 5'd10, 5'd12, "R9");

    // R1: mid-run reset clears everything
    do_reset();
    step(1'b0, 5'd0, 32'h0, 5'd10, 5'd31, "R1");
    step(1'b0, 5'd0, 32'h0, 5'd1, 5'd9, "R1");
    step(1'b0, 5'd0, 32'h0, 5'd12, 5'd7, "R1");
    for (int i = 0; i < 32; i += 2) begin
      step(1'b0, 5'd0, 32'h0, 5'(i), 5'(i + 1), "R1");
    end
    step(1'b1, 5'd20, 32'h7777_1111, 5'd20, 5'd0, "R2");
    step(1'b0, 5'd0, 32'h0, 5'd20, 5'd21, "R2");

    @(negedge clk);
    #3;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule